// File: doc/BRIEF.md
# Wrapping Hardware Stack Pointer

This block tracks the stack of a small 8-bit processor. The stack lives in one fixed 64-byte page at $00C0..$00FF. A 6-bit pointer selects the byte inside that page. The block always presents a full 16-bit memory address, with the upper ten bits tied to the page. The pointer always names the next free byte. A push writes at the pointer and then moves the pointer down. A pull first moves the pointer up and then reads. The pointer never leaves the page: moving past either end wraps it around, and older data is silently overwritten.

Besides single-byte push and pull, the block runs fixed multi-byte frames. A frame advances one byte per cycle, starting in the cycle its start input is high:

- a subroutine call pushes two bytes;
- a subroutine return pulls two bytes;
- an interrupt entry pushes five bytes;
- an interrupt return pulls five bytes.

During a pushing frame, the caller presents the byte for each cycle on the data input:

- for a call: return address low, then high;
- for an interrupt: PC low, PC high, X, A, CCR.

The pulls of the matching return then visit those bytes in reverse order. A reset-stack-pointer command puts the pointer back at the top of the page at any time. The memory array is outside the block. Write data is valid when the write enable is high. Read data is taken from the memory at the presented address in the same cycle.

Top module: `stack_ptr_unit`

## Requirements
- R1: While reset is high, and at the first clock edge after it, the pointer holds all ones. In that state the address is $00FF and the write enable is low.
- R2: When the rsp command is high, it overrides every other input and any frame in progress. In that cycle there is no write, and the address shows the current pointer. From the next cycle the pointer is all ones and no frame is running.
- R3: A push writes the data byte at address {page, pointer}, with the write enable high, in the same cycle. The pointer then decrements by one.
- R4: A pull presents address {page, pointer+1} with the write enable low in the same cycle. The pointer then increments by one.
- R5: Bits 15:6 of the address are always 0000000011, so the address stays within $00C0..$00FF.
- R6: The pointer wraps modulo 64 in both directions:
  - a push at $00C0 leaves the pointer at $00FF, so the 65th push overwrites the first byte;
  - a pull at pointer $00FF reads $00C0.
- R7: A call start begins a frame of exactly two push cycles, the first being the start cycle. Each cycle writes that cycle's data byte. The low return-address byte lands at the higher address.
- R8: A return start begins a frame of exactly two pull cycles. The high byte is read first and the low byte second.
- R9: An interrupt start begins a frame of exactly five push cycles. They write, at falling addresses, the bytes presented in order (PC low, PC high, X, A, CCR).
- R10: An interrupt-return start begins a frame of exactly five pull cycles. They read back CCR, A, X, PC high and PC low, one byte per cycle.
- R11: Push and pull high in the same cycle, with no frame and no rsp, leave the pointer unchanged and perform no write.
- R12: A frame start takes precedence over push and pull in its start cycle. While a frame runs, push, pull and further frame starts are ignored. Among simultaneous starts the priority is interrupt, call, interrupt return, return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Single-byte push request |
| pull | input | 1 | Single-byte pull request |
| rsp_cmd | input | 1 | Return the pointer to the top of the page |
| call_start | input | 1 | Begin a two-byte call frame |
| ret_start | input | 1 | Begin a two-byte return frame |
| irq_start | input | 1 | Begin a five-byte interrupt frame |
| rti_start | input | 1 | Begin a five-byte interrupt-return frame |
| data_in | input | 8 | Byte to write on a push cycle |
| mem_addr | output | 16 | Stack memory address |
| mem_we | output | 1 | Write enable for the stack memory |
| mem_wdata | output | 8 | Byte to write |

## Verification
The bench walks the pointer past the bottom of the page and past the top. A design that let the pointer escape the 64-byte window would present an address outside $00C0..$00FF, or fail to overwrite the oldest byte. It pushes full call and interrupt frames and then pulls them back through memory. A frame of the wrong length leaves the idle address off by the error, and a wrong pull order returns bytes in the wrong order. It raises push, pull and rsp while frames run. A sequencer that accepted a stray request would write or move the pointer once too often, and one that kept running after rsp would write after the pointer was reset.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int PTR_W    = 6;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 16;
    localparam int PAGE_W   = ADDR_W - PTR_W;
    localparam logic [PAGE_W-1:0] PAGE_HI = PAGE_W'(16'h00FF >> PTR_W);
    localparam int CALL_LEN = 2;
    localparam int IRQ_LEN  = 5;
    localparam int CNT_W    = $clog2(IRQ_LEN);

    typedef enum logic [1:0] {OP_HOLD, OP_PUSH, OP_PULL, OP_LOAD} sp_op_e;

    typedef struct packed {
        logic             active;
        logic             push_dir;
        logic [CNT_W-1:0] left;
    } frame_t;

    function automatic logic [ADDR_W-1:0] page_addr(input logic [PTR_W-1:0] p);
        return {PAGE_HI, p};
    endfunction
endpackage

// File: rtl/stk_frame_seq.sv
module stk_frame_seq
    import stk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   abort,
    input  logic   call_start,
    input  logic   ret_start,
    input  logic   irq_start,
    input  logic   rti_start,
    output frame_t fr_q,
    output logic   start_any,
    output logic   start_push
);
    logic [CNT_W-1:0] start_len;

    // Priority: interrupt, call, interrupt return, return
    always_comb begin
        start_any  = call_start | ret_start | irq_start | rti_start;
        start_push = irq_start | call_start;
        if (irq_start)       start_len = CNT_W'(IRQ_LEN);
        else if (call_start) start_len = CNT_W'(CALL_LEN);
        else if (rti_start)  start_len = CNT_W'(IRQ_LEN);
        else                 start_len = CNT_W'(CALL_LEN);
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            fr_q <= '0;
        end else if (fr_q.active) begin
            fr_q.left <= fr_q.left - 1'b1;
            if (fr_q.left == CNT_W'(1))
                fr_q.active <= 1'b0;
        end else if (start_any) begin
            fr_q.active   <= 1'b1;
            fr_q.push_dir <= start_push;
            fr_q.left     <= start_len - 1'b1;
        end
    end
endmodule

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg
    import stk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  sp_op_e           op,
    output logic [PTR_W-1:0] sp_q,
    output logic [PTR_W-1:0] sp_up
);
    assign sp_up = sp_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '1;
        end else begin
            case (op)
                OP_LOAD: sp_q <= '1;
                OP_PUSH: sp_q <= sp_q - 1'b1;
                OP_PULL: sp_q <= sp_up;
                default: sp_q <= sp_q;
            endcase
        end
    end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import stk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pull,
    input  logic              rsp_cmd,
    input  logic              call_start,
    input  logic              ret_start,
    input  logic              irq_start,
    input  logic              rti_start,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata
);
    frame_t           fr_q;
    logic             start_any;
    logic             start_push;
    logic             busy;
    sp_op_e           op;
    logic [PTR_W-1:0] sp_q;
    logic [PTR_W-1:0] sp_up;

    stk_frame_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .abort      (rsp_cmd),
        .call_start (call_start),
        .ret_start  (ret_start),
        .irq_start  (irq_start),
        .rti_start  (rti_start),
        .fr_q       (fr_q),
        .start_any  (start_any),
        .start_push (start_push)
    );

    stk_ptr_reg u_ptr (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .sp_q  (sp_q),
        .sp_up (sp_up)
    );

    assign busy = fr_q.active;

    always_comb begin
        if (rsp_cmd)           op = OP_LOAD;
        else if (busy)         op = fr_q.push_dir ? OP_PUSH : OP_PULL;
        else if (start_any)    op = start_push ? OP_PUSH : OP_PULL;
        else if (push && pull) op = OP_HOLD;
        else if (push)         op = OP_PUSH;
        else if (pull)         op = OP_PULL;
        else                   op = OP_HOLD;
    end

    always_comb begin
        mem_addr  = page_addr((op == OP_PULL) ? sp_up : sp_q);
        mem_we    = (op == OP_PUSH);
        mem_wdata = data_in;
    end
endmodule

// File: rtl/stk_ptr_chk.sv
module stk_ptr_chk
    import stk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              push,
    input logic              pull,
    input logic              rsp_cmd,
    input logic              start_any,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [PTR_W-1:0]  sp_q
);
    a_r1_reset_top: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> sp_q == '1);

    a_r2_rsp_top: assert property (@(posedge clk) disable iff (rst)
        rsp_cmd |=> (sp_q == '1 && !busy));

    a_r2_rsp_nowrite: assert property (@(posedge clk) disable iff (rst)
        rsp_cmd |-> !mem_we);

    a_r3_push_dec: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> sp_q == $past(sp_q) - 1'b1);

    a_r5_page: assert property (@(posedge clk) disable iff (rst)
        mem_addr[ADDR_W-1:PTR_W] == PAGE_HI);

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (push && pull && !rsp_cmd && !busy && !start_any) |=> $stable(sp_q));

    a_r12_frame_moves: assert property (@(posedge clk) disable iff (rst)
        (busy && !rsp_cmd) |=> sp_q != $past(sp_q));
endmodule

bind stack_ptr_unit stk_ptr_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .pull      (pull),
    .rsp_cmd   (rsp_cmd),
    .start_any (start_any),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .sp_q      (sp_q)
);

// File: tb/test_stack_ptr_unit.sv
`timescale 1ns/100ps
module test_stack_ptr_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic push = 0, pull = 0, rsp_cmd = 0;
    logic call_start = 0, ret_start = 0, irq_start = 0, rti_start = 0;
    logic [7:0]  data_in = 8'h00;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem [64];
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    stack_ptr_unit i_stack_ptr_unit (
        .clk(clk), .rst(rst), .push(push), .pull(pull), .rsp_cmd(rsp_cmd),
        .call_start(call_start), .ret_start(ret_start), .irq_start(irq_start),
        .rti_start(rti_start), .data_in(data_in),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    always @(posedge clk) if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;

    // {push, pull, rsp, data[7:0], expected addr[15:0], expected we}
    localparam int NV = 9;
    localparam logic [27:0] VEC [NV] = '{
        {3'b000, 8'h00, 16'h00FF, 1'b0},
        {3'b100, 8'hAA, 16'h00FF, 1'b1},
        {3'b100, 8'hBB, 16'h00FE, 1'b1},
        {3'b110, 8'h00, 16'h00FD, 1'b0},
        {3'b010, 8'h00, 16'h00FE, 1'b0},
        {3'b010, 8'h00, 16'h00FF, 1'b0},
        {3'b010, 8'h00, 16'h00C0, 1'b0},
        {3'b100, 8'h11, 16'h00C0, 1'b1},
        {3'b101, 8'h00, 16'h00FF, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(input logic p, input logic q, input logic r, input logic c,
                        input logic rt, input logic i, input logic ri, input logic [7:0] d);
        @(negedge clk);
        push = p; pull = q; rsp_cmd = r; call_start = c;
        ret_start = rt; irq_start = i; rti_start = ri; data_in = d;
        #1;
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 64; k++) mem[k] = 8'h00;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset addr", 32'(mem_addr), 32'h00FF);
        chk("R1 reset we", 32'(mem_we), 32'h0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 after reset addr", 32'(mem_addr), 32'h00FF);

        // R3 R4 R6 R11 R2: table walk
        for (int v = 0; v < NV; v++) begin
            step(VEC[v][27], VEC[v][26], VEC[v][25], 0, 0, 0, 0, VEC[v][24:17]);
            chk($sformatf("R3/R4/R6/R11 vec %0d addr", v), 32'(mem_addr), 32'(VEC[v][16:1]));
            chk($sformatf("R3/R4/R11 vec %0d we", v), 32'(mem_we), 32'(VEC[v][0]));
            if (v == 4) chk("R4 pull reads last pushed", 32'(mem[mem_addr[5:0]]), 32'hBB);
        end

        // R6 wrap after 64 pushes
        for (int k = 0; k < 64; k++) step(1, 0, 0, 0, 0, 0, 0, 8'(k));
        step(1, 0, 0, 0, 0, 0, 0, 8'hEE);
        chk("R6 65th push addr", 32'(mem_addr), 32'h00FF);
        chk("R5 page bits", 32'(mem_addr[15:6]), 32'h3);
        step(0, 0, 1, 0, 0, 0, 0, 8'h00);
        chk("R2 rsp no write", 32'(mem_we), 32'h0);
        chk("R6 overwrite oldest", 32'(mem[6'h3F]), 32'hEE);
        step(0, 0, 0, 0, 0, 0, 0, 8'h00);
        chk("R2 rsp to top", 32'(mem_addr), 32'h00FF);

        // R7 call frame, push also high in start cycle, pull stray in cycle 2
        step(1, 0, 0, 1, 0, 0, 0, 8'h34);
        chk("R7 call byte0 addr", 32'(mem_addr), 32'h00FF);
        chk("R7 call byte0 we", 32'(mem_we), 32'h1);
        step(0, 1, 0, 0, 0, 0, 0, 8'h12);
        chk("R12 call byte1 ignores pull", 32'(mem_addr), 32'h00FE);
        chk("R7 call byte1 we", 32'(mem_we), 32'h1);
        step(0, 0, 0, 0, 0, 0, 0, 8'h00);
        chk("R7 call frame length", 32'(mem_addr), 32'h00FD);

        // R8 return frame
        step(0, 0, 0, 0, 1, 0, 0, 8'h00);
        chk("R8 ret first high byte", 32'(mem[mem_addr[5:0]]), 32'h12);
        chk("R8 ret no write", 32'(mem_we), 32'h0);
        step(1, 0, 0, 0, 0, 0, 0, 8'h99);
        chk("R12 ret ignores push we", 32'(mem_we), 32'h0);
        chk("R8 ret second low byte", 32'(mem[mem_addr[5:0]]), 32'h34);
        step(0, 0, 0, 0, 0, 0, 0, 8'h00);
        chk("R8 ret frame length", 32'(mem_addr), 32'h00FF);

        // R9 interrupt frame: PCL PCH X A CCR
        for (int k = 0; k < 5; k++) begin
            step(0, 0, 0, 0, 0, k == 0, 0, 8'(k + 1));
            chk($sformatf("R9 irq byte %0d addr", k), 32'(mem_addr), 32'h00FF - k);
            chk($sformatf("R9 irq byte %0d we", k), 32'(mem_we), 32'h1);
        end
        step(0, 0, 0, 0, 0, 0, 0, 8'h00);
        chk("R9 irq frame length", 32'(mem_addr), 32'h00FA);

        // R10 interrupt return
        for (int k = 0; k < 5; k++) begin
            step(0, 0, 0, 0, 0, 0, k == 0, 8'h00);
            chk($sformatf("R10 rti byte %0d data", k), 32'(mem[mem_addr[5:0]]), 32'(5 - k));
        end
        step(0, 0, 0, 0, 0, 0, 0, 8'h00);
        chk("R10 rti frame length", 32'(mem_addr), 32'h00FF);

        // R12 priority: irq beats call in the same cycle
        step(0, 0, 0, 1, 0, 1, 0, 8'hC1);
        step(0, 0, 0, 0, 0, 0, 0, 8'hC2);
        step(0, 0, 0, 0, 0, 0, 0, 8'hC3);
        chk("R12 irq wins over call", 32'(mem_we), 32'h1);

        // R2 rsp cancels running frame
        step(0, 0, 1, 0, 0, 0, 0, 8'h00);
        chk("R2 rsp mid-frame no write", 32'(mem_we), 32'h0);
        step(0, 0, 0, 0, 0, 0, 0, 8'h00);
        chk("R2 frame cancelled we", 32'(mem_we), 32'h0);
        chk("R2 frame cancelled addr", 32'(mem_addr), 32'h00FF);

        step(0, 0, 0, 0, 0, 0, 0, 8'h00);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule